// File: doc/BRIEF.md
# Return Address Stack with Fault Reset

This block is the hardware call stack of a small processor core. A call pushes the 21-bit return address, and a return pops it. The current top entry is always visible on an output. The stack holds 31 entries, tracked by a 5-bit occupancy pointer. An empty stack shows an address of zero.

Two fault conditions are tracked:
- **Full:** a push that fills the last entry, or a push attempted while the stack is already full.
- **Underflow:** a pop attempted while the stack is empty.

Each condition latches a sticky flag. The flag stays set until software pulses its clear strobe or a power-on reset occurs. A configuration input selects what else happens on a fault. When it is high, the fault also produces a one-cycle reset request to the chip's reset generator. When it is low, only the flag records the fault.

The push and pop strobes are plain single-cycle controls, not a valid/ready stream. The stack accepts an operation every cycle and never applies back-pressure. A core reset empties the stack but keeps both flags, so software can inspect them after a fault-triggered reset.

Top module: `retstack`

## Requirements
- R1: A push (push_i high, pop_i low) stores push_addr_i; from the next cycle tos_addr_o shows that address.
- R2: A pop on a non-empty stack removes the top entry; from the next cycle tos_addr_o shows the entry below it, or zero if the stack is now empty.
- R3: The push that stores the 31st entry sets full_flag_o in the following cycle; after only 30 pushes the flag is still low.
- R4: A push while 31 entries are held writes nothing: tos_addr_o and all stored entries keep their values, and full_flag_o stays high.
- R5: A pop while empty sets uflow_flag_o in the next cycle; the stack stays empty and tos_addr_o reads zero.
- R6: With rst_on_fault_i high, each full or underflow event drives reset_req_o high for exactly the one cycle after the event, alongside the flag.
- R7: With rst_on_fault_i low, a full or underflow event sets its flag but reset_req_o stays low.
- R8: Each flag stays set until its clear strobe (clr_full_i or clr_uflow_i) is pulsed. If a clear and a new event of the same kind arrive in the same cycle, the flag stays set.
- R9: core_rst_i empties the stack (tos_addr_o reads zero) and leaves both flags unchanged.
- R10: por_i empties the stack and clears both flags and reset_req_o.
- R11: push_i and pop_i high in the same cycle is a no-op: the stack contents, tos_addr_o and both flags are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_i | input | 1 | Power-on reset, synchronous, active high |
| core_rst_i | input | 1 | Core reset; empties the stack and keeps the flags |
| push_i | input | 1 | Push strobe (call) |
| pop_i | input | 1 | Pop strobe (return) |
| push_addr_i | input | 21 | Return address to store |
| rst_on_fault_i | input | 1 | Configuration: faults also request a device reset |
| clr_full_i | input | 1 | Software strobe clearing the full flag |
| clr_uflow_i | input | 1 | Software strobe clearing the underflow flag |
| tos_addr_o | output | 21 | Top-of-stack address, zero when empty |
| full_flag_o | output | 1 | Sticky full flag |
| uflow_flag_o | output | 1 | Sticky underflow flag |
| reset_req_o | output | 1 | One-cycle device reset request |

## Verification
Every result lands one clock edge after its stimulus: the top-of-stack value, both flags and the reset request are all registered once. The bench applies each strobe at a falling edge and lets one rising edge pass. It then samples at the following falling edge, where the new top, the flags and a pending reset pulse must all be visible. One further cycle later it checks that the reset request has dropped again, which confirms the pulse lasts a single cycle. Clear strobes and resets are checked the same way, one edge after they are applied.

// File: rtl/retstack_pkg.sv
package retstack_pkg;
  localparam int unsigned RS_ADDR_W = 21;
  localparam int unsigned RS_DEPTH  = 31;

  function automatic int unsigned rs_ptr_w(input int unsigned depth);
    return $clog2(depth + 1);
  endfunction
endpackage

// File: rtl/rs_ptr.sv
module rs_ptr #(
  parameter int unsigned DEPTH = 31,
  localparam int unsigned PW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          por_i,
  input  logic          core_rst_i,
  input  logic          push_i,
  input  logic          pop_i,
  output logic [PW-1:0] ptr_o,
  output logic          wr_en_o,
  output logic          full_evt_o,
  output logic          uflow_evt_o
);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [PW-1:0] TOP  = PW'(DEPTH);

  logic [PW-1:0] ptr_q;
  logic do_push, do_pop;

  // push and pop together cancel out
  assign do_push     = push_i & ~pop_i & ~core_rst_i;
  assign do_pop      = pop_i & ~push_i & ~core_rst_i;
  assign wr_en_o     = do_push && (ptr_q < TOP);
  assign full_evt_o  = do_push && (ptr_q >= LAST);
  assign uflow_evt_o = do_pop && (ptr_q == '0);
  assign ptr_o       = ptr_q;

  always_ff @(posedge clk) begin
    if (por_i || core_rst_i)        ptr_q <= '0;
    else if (wr_en_o)               ptr_q <= ptr_q + 1'b1;
    else if (do_pop && ptr_q != '0) ptr_q <= ptr_q - 1'b1;
  end

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (por_i || core_rst_i)
    (ptr_q == TOP && push_i && !pop_i) |=> (ptr_q == TOP));
  a_r11_both_noop: assert property (@(posedge clk) disable iff (por_i || core_rst_i)
    (push_i && pop_i) |=> $stable(ptr_q));
  a_r5_empty_stays: assert property (@(posedge clk) disable iff (por_i || core_rst_i)
    (ptr_q == '0 && pop_i && !push_i) |=> (ptr_q == '0));
endmodule

// File: rtl/rs_mem.sv
module rs_mem #(
  parameter int unsigned AW = 21,
  parameter int unsigned DEPTH = 31,
  localparam int unsigned PW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          wr_en_i,
  input  logic [PW-1:0] ptr_i,
  input  logic [AW-1:0] din_i,
  output logic [AW-1:0] tos_o
);
  logic [AW-1:0] ent [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (wr_en_i && ptr_i == PW'(g)) ent[g] <= din_i;
    end
  end

  // entry ptr-1 is the top; an empty stack reads zero
  always_comb begin
    tos_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (ptr_i == PW'(i + 1)) tos_o = ent[i];
    end
  end
endmodule

// File: rtl/rs_flags.sv
module rs_flags (
  input  logic clk,
  input  logic por_i,
  input  logic full_evt_i,
  input  logic uflow_evt_i,
  input  logic clr_full_i,
  input  logic clr_uflow_i,
  input  logic rst_en_i,
  output logic full_o,
  output logic uflow_o,
  output logic req_o
);
  always_ff @(posedge clk) begin
    if (por_i) begin
      full_o  <= 1'b0;
      uflow_o <= 1'b0;
      req_o   <= 1'b0;
    end else begin
      // a new event wins over a clear in the same cycle
      full_o  <= full_evt_i  | (full_o  & ~clr_full_i);
      uflow_o <= uflow_evt_i | (uflow_o & ~clr_uflow_i);
      req_o   <= rst_en_i & (full_evt_i | uflow_evt_i);
    end
  end

  a_r8_full_sticky: assert property (@(posedge clk) disable iff (por_i)
    (full_o && !clr_full_i) |=> full_o);
  a_r8_uflow_sticky: assert property (@(posedge clk) disable iff (por_i)
    (uflow_o && !clr_uflow_i) |=> uflow_o);
  a_r7_no_req_when_off: assert property (@(posedge clk) disable iff (por_i)
    !rst_en_i |=> !req_o);
  a_r6_req_has_cause: assert property (@(posedge clk) disable iff (por_i)
    (full_evt_i || uflow_evt_i) && rst_en_i |=> req_o);
endmodule

// File: rtl/retstack.sv
module retstack
  import retstack_pkg::*;
#(
  parameter int unsigned ADDR_W = RS_ADDR_W,
  parameter int unsigned DEPTH  = RS_DEPTH
) (
  input  logic              clk,
  input  logic              por_i,
  input  logic              core_rst_i,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [ADDR_W-1:0] push_addr_i,
  input  logic              rst_on_fault_i,
  input  logic              clr_full_i,
  input  logic              clr_uflow_i,
  output logic [ADDR_W-1:0] tos_addr_o,
  output logic              full_flag_o,
  output logic              uflow_flag_o,
  output logic              reset_req_o
);
  localparam int unsigned PW = $clog2(DEPTH + 1);

  logic [PW-1:0] ptr;
  logic wr_en, full_evt, uflow_evt;

  rs_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .por_i(por_i), .core_rst_i(core_rst_i),
    .push_i(push_i), .pop_i(pop_i), .ptr_o(ptr),
    .wr_en_o(wr_en), .full_evt_o(full_evt), .uflow_evt_o(uflow_evt)
  );

  rs_mem #(.AW(ADDR_W), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .wr_en_i(wr_en), .ptr_i(ptr),
    .din_i(push_addr_i), .tos_o(tos_addr_o)
  );

  rs_flags u_flags (
    .clk(clk), .por_i(por_i),
    .full_evt_i(full_evt), .uflow_evt_i(uflow_evt),
    .clr_full_i(clr_full_i), .clr_uflow_i(clr_uflow_i),
    .rst_en_i(rst_on_fault_i),
    .full_o(full_flag_o), .uflow_o(uflow_flag_o), .req_o(reset_req_o)
  );

  a_r5_uflow_reads_zero: assert property (@(posedge clk) disable iff (por_i || core_rst_i)
    (pop_i && !push_i && !uflow_flag_o && tos_addr_o == '0) |=> (tos_addr_o == '0));
  a_r9_core_rst_keeps_flags: assert property (@(posedge clk) disable iff (por_i)
    (core_rst_i && full_flag_o && !clr_full_i) |=> full_flag_o);
endmodule

// File: tb/retstack_bench.sv
module retstack_bench;
  localparam int AW = 21;
  logic clk = 1'b0;
  logic por_i = 1'b1, core_rst_i = 1'b0, push_i = 1'b0, pop_i = 1'b0;
  logic [AW-1:0] push_addr_i = '0;
  logic rst_on_fault_i = 1'b0, clr_full_i = 1'b0, clr_uflow_i = 1'b0;
  logic [AW-1:0] tos_addr_o;
  logic full_flag_o, uflow_flag_o, reset_req_o;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  retstack u_retstack (.*);

  function automatic logic [AW-1:0] val(input int i);
    return AW'(21'h10000 + i * 37);
  endfunction

  task automatic chk(input string tag, input string what, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
    push_i = 0; pop_i = 0; core_rst_i = 0; por_i = 0; clr_full_i = 0; clr_uflow_i = 0;
  endtask

  task automatic do_push(input logic [AW-1:0] a);
    push_i = 1; push_addr_i = a; tick();
  endtask

  task automatic do_pop();
    pop_i = 1; tick();
  endtask

  task automatic t_reset();
    por_i = 1; tick();
    chk("R10", "tos", tos_addr_o, '0);
    chk("R10", "full", AW'(full_flag_o), '0);
    chk("R10", "uflow", AW'(uflow_flag_o), '0);
    chk("R10", "req", AW'(reset_req_o), '0);
  endtask

  task automatic t_push_pop();
    do_push(21'h00ABC); chk("R1", "tos A", tos_addr_o, 21'h00ABC);
    do_push(21'h1F00F); chk("R1", "tos B", tos_addr_o, 21'h1F00F);
    do_pop(); chk("R2", "pop to A", tos_addr_o, 21'h00ABC);
    do_pop(); chk("R2", "pop to empty", tos_addr_o, '0);
    chk("R2", "no uflow", AW'(uflow_flag_o), '0);
  endtask

  task automatic t_fill();
    rst_on_fault_i = 1;
    for (int i = 1; i <= 30; i++) do_push(val(i));
    chk("R3", "full after 30", AW'(full_flag_o), '0);
    do_push(val(31));
    chk("R3", "full after 31", AW'(full_flag_o), 1);
    chk("R6", "req on full", AW'(reset_req_o), 1);
    chk("R1", "tos 31", tos_addr_o, val(31));
    tick();
    chk("R6", "req one cycle", AW'(reset_req_o), 0);
    rst_on_fault_i = 0;
    do_push(21'h1FFFF);
    chk("R4", "tos kept", tos_addr_o, val(31));
    chk("R4", "full kept", AW'(full_flag_o), 1);
    chk("R7", "no req", AW'(reset_req_o), 0);
    do_pop();
    chk("R4", "entry 30 intact", tos_addr_o, val(30));
    core_rst_i = 1; tick();
    chk("R9", "tos empty", tos_addr_o, '0);
    chk("R9", "full kept", AW'(full_flag_o), 1);
    tick();
    chk("R8", "full sticky", AW'(full_flag_o), 1);
    clr_full_i = 1; tick();
    chk("R8", "full cleared", AW'(full_flag_o), 0);
  endtask

  task automatic t_underflow();
    rst_on_fault_i = 0;
    do_pop();
    chk("R5", "uflow set", AW'(uflow_flag_o), 1);
    chk("R5", "tos zero", tos_addr_o, '0);
    chk("R7", "no req", AW'(reset_req_o), 0);
    pop_i = 1; clr_uflow_i = 1; tick();
    chk("R8", "set wins clear", AW'(uflow_flag_o), 1);
    clr_uflow_i = 1; tick();
    chk("R8", "uflow cleared", AW'(uflow_flag_o), 0);
    rst_on_fault_i = 1;
    do_pop();
    chk("R6", "req on uflow", AW'(reset_req_o), 1);
    chk("R6", "uflow flag", AW'(uflow_flag_o), 1);
    tick();
    chk("R6", "req dropped", AW'(reset_req_o), 0);
    do_push(21'h00777);
    chk("R5", "stack still usable", tos_addr_o, 21'h00777);
    do_pop();
    rst_on_fault_i = 0;
  endtask

  task automatic t_both();
    do_push(21'h0A0A0);
    push_i = 1; pop_i = 1; push_addr_i = 21'h05050; tick();
    chk("R11", "tos unchanged", tos_addr_o, 21'h0A0A0);
    do_pop();
    chk("R11", "single entry", tos_addr_o, '0);
    pop_i = 1; push_i = 1; clr_uflow_i = 1; tick();
    chk("R11", "empty both no uflow", AW'(uflow_flag_o), 0);
  endtask

  task automatic t_por();
    do_pop();
    chk("R5", "uflow before por", AW'(uflow_flag_o), 1);
    do_push(21'h00123);
    por_i = 1; tick();
    chk("R10", "por clears uflow", AW'(uflow_flag_o), 0);
    chk("R10", "por empties", tos_addr_o, '0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_push_pop();
    t_fill();
    t_underflow();
    t_both();
    t_por();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule